// File: doc/BRIEF.md
# Keyed Watchdog Timer with Early-Warning Interrupt

This block is a watchdog timer for a system bus. It runs on the bus clock. A single-cycle tick input, pulsed at 32768 Hz, sets the counting rate. A timeout of N seconds therefore needs a load value of N times 32768. Software must write a 16-bit key into the lock register before the block accepts any configuration or clear write. Writing any other value to that register closes the block again.

Software loads a 32-bit timeout and a 32-bit early-warning threshold, each as two 16-bit halves. Each accepted write to one of these four registers starts a transfer. A busy flag is set and stays set for three ticks. When the transfer completes, the counter takes the new timeout and the threshold register takes the new threshold. Reloading while the counter runs is how the watchdog is serviced.

While counting is enabled, each tick lowers the counter by one. The counter stops at zero. Arriving at the threshold raises a maskable interrupt event. Arriving at zero raises the reset event, which drives the reset request output.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the block is locked, every register reads zero, and both outputs are low.
- R2: Writing 0xE551 to the lock register (byte offset 0x20) unlocks the block, and writing any other value locks it. The lock register reads 1 while unlocked and 0 while locked.
- R3: While locked, writes to every register other than the lock register are ignored.
- R4: The timeout halves sit at offsets 0x00 (low) and 0x04 (high). The threshold halves sit at 0x2C (low) and 0x30 (high). Each is a 16-bit register that reads back what was written.
- R5: Status bit 4 (status register at 0x10) is set by any accepted write to a load register. It clears on the third tick after the last such write, and a new load write restarts the three-tick wait.
- R6: In the cycle busy clears, the counter is loaded with {timeout high, timeout low} and the threshold with {threshold high, threshold low}. This happens even while counting is enabled.
- R7: Control register 0x08 has four bits: bit 0 interrupt enable, bit 1 count enable, bit 2 a stored mode flag, bit 3 reset enable. With bit 1 set, each tick outside a transfer lowers the counter by one, borrowing across the 16-bit halves. The counter holds at zero. The count is readable at 0x18 (low half) and 0x1C (high half).
- R8: Status bit 0 sets on the tick that lowers the counter onto the threshold. The interrupt output equals status bit 0 AND interrupt enable AND NOT the mask bit (bit 0 at 0x14).
- R9: Status bit 3 sets on the tick that lowers the counter from 1 to 0. The reset request output equals status bit 3 AND reset enable AND count enable.
- R10: Writing the clear register at 0x0C with bit 0 set clears status bit 0. Writing it with bit 3 set clears status bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle count enable pulse at 32768 Hz |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | HALF_W | Write data |
| rdata | output | HALF_W | Read data for addr, combinational |
| irq_o | output | 1 | Early-warning interrupt |
| rst_req_o | output | 1 | Reset request |

## Verification
The assertions take for granted that tick is a single-cycle pulse. They also assume that software does not start a new load while a transfer tick is arriving. A load write in that cycle restarts the wait instead of transferring.

The counter properties hold only when no transfer is pending. For that reason the stimulus starts counting checks only after busy has cleared. The bench drives tick and bus writes in separate cycles, so no write and no tick ever share an edge.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
   localparam logic [7:0] OFS_LD_LO  = 8'h00;
   localparam logic [7:0] OFS_LD_HI  = 8'h04;
   localparam logic [7:0] OFS_CTRL   = 8'h08;
   localparam logic [7:0] OFS_CLR    = 8'h0C;
   localparam logic [7:0] OFS_STAT   = 8'h10;
   localparam logic [7:0] OFS_MASK   = 8'h14;
   localparam logic [7:0] OFS_CNT_LO = 8'h18;
   localparam logic [7:0] OFS_CNT_HI = 8'h1C;
   localparam logic [7:0] OFS_LOCK   = 8'h20;
   localparam logic [7:0] OFS_PR_LO  = 8'h2C;
   localparam logic [7:0] OFS_PR_HI  = 8'h30;

   // control bits, msb first: bit3 rst_en, bit2 mode, bit1 cnt_en, bit0 int_en
   typedef struct packed {
      logic rst_en;
      logic mode;
      logic cnt_en;
      logic int_en;
   } ctrl_t;

   localparam int EV_INT = 0;
   localparam int EV_RST = 1;
   localparam int NUM_EV = 2;
   localparam int ST_INT_BIT  = 0;
   localparam int ST_RST_BIT  = 3;
   localparam int ST_BUSY_BIT = 4;
endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
   import kwd_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int HALF_W = 16,
   parameter logic [HALF_W-1:0] KEY = 16'hE551,
   localparam int CNT_W = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [HALF_W-1:0] wdata,
   output logic              unlocked,
   output ctrl_t             ctrl_q,
   output logic              mask_q,
   output logic [CNT_W-1:0]  ld_val,
   output logic [CNT_W-1:0]  pr_val,
   output logic              load_wr,
   output logic              clr_int,
   output logic              clr_rst
);
   logic [HALF_W-1:0] ld_lo, ld_hi, pr_lo, pr_hi;
   logic              acc;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
      return a == ADDR_W'(ofs);
   endfunction

   assign acc     = wr_en && unlocked;
   assign load_wr = acc && (hit(addr, OFS_LD_LO) || hit(addr, OFS_LD_HI) ||
                            hit(addr, OFS_PR_LO) || hit(addr, OFS_PR_HI));
   assign clr_int = acc && hit(addr, OFS_CLR) && wdata[ST_INT_BIT];
   assign clr_rst = acc && hit(addr, OFS_CLR) && wdata[ST_RST_BIT];
   assign ld_val  = {ld_hi, ld_lo};
   assign pr_val  = {pr_hi, pr_lo};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unlocked <= 1'b0;
      end else if (wr_en && hit(addr, OFS_LOCK)) begin
         unlocked <= (wdata == KEY);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_lo  <= '0;
         ld_hi  <= '0;
         pr_lo  <= '0;
         pr_hi  <= '0;
         ctrl_q <= '0;
         mask_q <= 1'b0;
      end else if (acc) begin
         if (hit(addr, OFS_LD_LO)) ld_lo <= wdata;
         if (hit(addr, OFS_LD_HI)) ld_hi <= wdata;
         if (hit(addr, OFS_PR_LO)) pr_lo <= wdata;
         if (hit(addr, OFS_PR_HI)) pr_hi <= wdata;
         if (hit(addr, OFS_CTRL))  ctrl_q <= ctrl_t'(wdata[3:0]);
         if (hit(addr, OFS_MASK))  mask_q <= wdata[0];
      end
   end
endmodule

// File: rtl/kwd_loader.sv
module kwd_loader #(
   parameter int XFER_TICKS = 3,
   localparam int TCW = (XFER_TICKS > 2) ? $clog2(XFER_TICKS) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic load_wr,
   output logic busy,
   output logic xfer
);
   localparam logic [TCW-1:0] LAST = TCW'(XFER_TICKS - 1);
   logic [TCW-1:0] tcnt;

   assign xfer = busy && tick && !load_wr && (tcnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         tcnt <= '0;
      end else if (load_wr) begin
         busy <= 1'b1;
         tcnt <= '0;
      end else if (busy && tick) begin
         if (tcnt == LAST) begin
            busy <= 1'b0;
            tcnt <= '0;
         end else begin
            tcnt <= tcnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter
   import kwd_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cnt_en,
   input  logic             xfer,
   input  logic [CNT_W-1:0] ld_val,
   input  logic [CNT_W-1:0] pr_val,
   input  logic             clr_int,
   input  logic             clr_rst,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] thr_q,
   output logic             int_raw,
   output logic             rst_raw
);
   logic [CNT_W-1:0]  nxt;
   logic              dec;
   logic [NUM_EV-1:0] ev_set, ev_clr, ev_q;

   assign nxt = cnt_q - 1'b1;
   assign dec = tick && cnt_en && !xfer && (cnt_q != '0);

   assign ev_set[EV_INT] = dec && (nxt == thr_q);
   assign ev_set[EV_RST] = dec && (nxt == '0);
   assign ev_clr[EV_INT] = clr_int;
   assign ev_clr[EV_RST] = clr_rst;
   assign int_raw = ev_q[EV_INT];
   assign rst_raw = ev_q[EV_RST];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         thr_q <= '0;
      end else if (xfer) begin
         cnt_q <= ld_val;
         thr_q <= pr_val;
      end else if (dec) begin
         cnt_q <= nxt;
      end
   end

   // one sticky flag per event; a set in the same cycle as its clear wins
   for (genvar k = 0; k < NUM_EV; k++) begin : g_ev
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         ev_q[k] <= 1'b0;
         else if (ev_set[k]) ev_q[k] <= 1'b1;
         else if (ev_clr[k]) ev_q[k] <= 1'b0;
      end
   end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
   import kwd_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int HALF_W = 16,
   parameter int XFER_TICKS = 3,
   parameter logic [HALF_W-1:0] KEY = 16'hE551
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [HALF_W-1:0] wdata,
   output logic [HALF_W-1:0] rdata,
   output logic              irq_o,
   output logic              rst_req_o
);
   localparam int CNT_W = 2 * HALF_W;

   if (ADDR_W < 6) begin : g_bad_addr
      $error("keyed_watchdog: ADDR_W must cover offset 0x30");
   end
   if (HALF_W < 8) begin : g_bad_half
      $error("keyed_watchdog: HALF_W must hold the status bits");
   end
   if (XFER_TICKS < 2) begin : g_bad_xfer
      $error("keyed_watchdog: XFER_TICKS must be at least 2");
   end

   logic             unlocked, mask_q, load_wr, clr_int, clr_rst;
   logic             busy, xfer, int_raw, rst_raw;
   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] ld_val, pr_val, cnt_q, thr_q;

   kwd_regs #(.ADDR_W(ADDR_W), .HALF_W(HALF_W), .KEY(KEY)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .unlocked(unlocked), .ctrl_q(ctrl_q), .mask_q(mask_q),
      .ld_val(ld_val), .pr_val(pr_val), .load_wr(load_wr),
      .clr_int(clr_int), .clr_rst(clr_rst)
   );

   kwd_loader #(.XFER_TICKS(XFER_TICKS)) u_load (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load_wr(load_wr),
      .busy(busy), .xfer(xfer)
   );

   kwd_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_en(ctrl_q.cnt_en),
      .xfer(xfer), .ld_val(ld_val), .pr_val(pr_val),
      .clr_int(clr_int), .clr_rst(clr_rst),
      .cnt_q(cnt_q), .thr_q(thr_q), .int_raw(int_raw), .rst_raw(rst_raw)
   );

   assign irq_o     = int_raw && ctrl_q.int_en && !mask_q;
   assign rst_req_o = rst_raw && ctrl_q.rst_en && ctrl_q.cnt_en;

   always_comb begin
      rdata = '0;
      unique case (addr)
         ADDR_W'(OFS_LD_LO):  rdata = ld_val[HALF_W-1:0];
         ADDR_W'(OFS_LD_HI):  rdata = ld_val[CNT_W-1:HALF_W];
         ADDR_W'(OFS_PR_LO):  rdata = pr_val[HALF_W-1:0];
         ADDR_W'(OFS_PR_HI):  rdata = pr_val[CNT_W-1:HALF_W];
         ADDR_W'(OFS_CTRL):   rdata[3:0] = ctrl_q;
         ADDR_W'(OFS_MASK):   rdata[0] = mask_q;
         ADDR_W'(OFS_CNT_LO): rdata = cnt_q[HALF_W-1:0];
         ADDR_W'(OFS_CNT_HI): rdata = cnt_q[CNT_W-1:HALF_W];
         ADDR_W'(OFS_LOCK):   rdata[0] = unlocked;
         ADDR_W'(OFS_STAT): begin
            rdata[ST_INT_BIT]  = int_raw;
            rdata[ST_RST_BIT]  = rst_raw;
            rdata[ST_BUSY_BIT] = busy;
         end
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             irq_o,
   input logic             unlocked,
   input logic [3:0]       ctrl,
   input logic             mask_q,
   input logic             busy,
   input logic             load_wr,
   input logic             clr_int,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] thr_q,
   input logic             int_raw,
   input logic             rst_raw
);
   a_r3_locked_ctrl_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |=> $stable(ctrl));
   a_r3_locked_no_load: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |=> !$rose(busy));
   a_r5_busy_on_load: assert property (@(posedge clk) disable iff (!rst_n)
      load_wr |=> busy);
   a_r5_busy_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(tick));
   a_r7_dec_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && ctrl[1] && !busy && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
   a_r7_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !busy) |=> cnt_q == '0);
   a_r8_int_at_thr: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_raw) |-> cnt_q == thr_q);
   a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      mask_q |-> !irq_o);
   a_r9_rst_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_raw) |-> (cnt_q == '0 && $past(cnt_q) == CNT_W'(1)));
   a_r10_int_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(int_raw) |-> $past(clr_int));
endmodule

bind keyed_watchdog keyed_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .irq_o(irq_o),
   .unlocked(unlocked), .ctrl(ctrl_q), .mask_q(mask_q), .busy(busy),
   .load_wr(load_wr), .clr_int(clr_int), .cnt_q(cnt_q), .thr_q(thr_q),
   .int_raw(int_raw), .rst_raw(rst_raw)
);

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [5:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        irq_o, rst_req_o;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   keyed_watchdog uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .rst_req_o(rst_req_o)
   );

   localparam logic [5:0] A_LD_LO = 6'h00, A_LD_HI = 6'h04, A_CTRL = 6'h08,
                          A_CLR = 6'h0C, A_STAT = 6'h10, A_MASK = 6'h14,
                          A_CNT_LO = 6'h18, A_CNT_HI = 6'h1C, A_LOCK = 6'h20,
                          A_PR_LO = 6'h2C, A_PR_HI = 6'h30;
   localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2;

   // eo = {rst_req_o, irq_o} expected after the row
   typedef struct packed {
      logic [1:0]  op;
      logic [5:0]  addr;
      logic [15:0] data;
      logic [15:0] exp;
      logic [1:0]  eo;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 44;
   localparam vec_t VT [NV] = '{
      '{OP_RD, A_CTRL,   16'h0,    16'h0,  2'b00, 4'd1},  // R1
      '{OP_RD, A_LOCK,   16'h0,    16'h0,  2'b00, 4'd1},  // R1
      '{OP_RD, A_STAT,   16'h0,    16'h0,  2'b00, 4'd1},  // R1
      '{OP_WR, A_LD_LO,  16'h0010, 16'h0,  2'b00, 4'd3},  // R3 locked write
      '{OP_RD, A_LD_LO,  16'h0,    16'h0,  2'b00, 4'd3},  // R3
      '{OP_RD, A_STAT,   16'h0,    16'h0,  2'b00, 4'd3},  // R3 no busy
      '{OP_WR, A_LOCK,   16'h1234, 16'h0,  2'b00, 4'd2},  // R2 wrong key
      '{OP_RD, A_LOCK,   16'h0,    16'h0,  2'b00, 4'd2},  // R2
      '{OP_WR, A_LOCK,   16'hE551, 16'h0,  2'b00, 4'd2},  // R2 key
      '{OP_RD, A_LOCK,   16'h0,    16'h1,  2'b00, 4'd2},  // R2
      '{OP_WR, A_LD_HI,  16'h0,    16'h0,  2'b00, 4'd4},  // R4
      '{OP_WR, A_LD_LO,  16'h6,    16'h0,  2'b00, 4'd4},  // R4
      '{OP_WR, A_PR_LO,  16'h3,    16'h0,  2'b00, 4'd4},  // R4
      '{OP_WR, A_PR_HI,  16'h0,    16'h0,  2'b00, 4'd4},  // R4
      '{OP_RD, A_PR_LO,  16'h0,    16'h3,  2'b00, 4'd4},  // R4
      '{OP_RD, A_STAT,   16'h0,    16'h10, 2'b00, 4'd5},  // R5 busy
      '{OP_TK, 6'h0,     16'd2,    16'h0,  2'b00, 4'd5},  // R5
      '{OP_RD, A_STAT,   16'h0,    16'h10, 2'b00, 4'd5},  // R5 still busy
      '{OP_TK, 6'h0,     16'd1,    16'h0,  2'b00, 4'd5},  // R5 third tick
      '{OP_RD, A_STAT,   16'h0,    16'h0,  2'b00, 4'd5},  // R5 done
      '{OP_RD, A_CNT_LO, 16'h0,    16'h6,  2'b00, 4'd6},  // R6
      '{OP_RD, A_CNT_HI, 16'h0,    16'h0,  2'b00, 4'd6},  // R6
      '{OP_WR, A_CTRL,   16'hB,    16'h0,  2'b00, 4'd7},  // R7
      '{OP_RD, A_CTRL,   16'h0,    16'hB,  2'b00, 4'd7},  // R7
      '{OP_TK, 6'h0,     16'd2,    16'h0,  2'b00, 4'd7},  // R7
      '{OP_RD, A_CNT_LO, 16'h0,    16'h4,  2'b00, 4'd7},  // R7 6->4
      '{OP_TK, 6'h0,     16'd1,    16'h0,  2'b01, 4'd8},  // R8 hits 3
      '{OP_RD, A_STAT,   16'h0,    16'h1,  2'b01, 4'd8},  // R8
      '{OP_WR, A_MASK,   16'h1,    16'h0,  2'b00, 4'd8},  // R8 masked
      '{OP_RD, A_STAT,   16'h0,    16'h1,  2'b00, 4'd8},  // R8 raw kept
      '{OP_WR, A_CLR,    16'h1,    16'h0,  2'b00, 4'd10}, // R10
      '{OP_RD, A_STAT,   16'h0,    16'h0,  2'b00, 4'd10}, // R10
      '{OP_WR, A_MASK,   16'h0,    16'h0,  2'b00, 4'd8},  // R8
      '{OP_TK, 6'h0,     16'd2,    16'h0,  2'b00, 4'd9},  // R9 down to 1
      '{OP_TK, 6'h0,     16'd1,    16'h0,  2'b10, 4'd9},  // R9 zero
      '{OP_RD, A_STAT,   16'h0,    16'h8,  2'b10, 4'd9},  // R9
      '{OP_TK, 6'h0,     16'd2,    16'h0,  2'b10, 4'd7},  // R7 hold
      '{OP_RD, A_CNT_LO, 16'h0,    16'h0,  2'b10, 4'd7},  // R7
      '{OP_WR, A_CLR,    16'h8,    16'h0,  2'b00, 4'd10}, // R10
      '{OP_RD, A_STAT,   16'h0,    16'h0,  2'b00, 4'd10}, // R10
      '{OP_WR, A_LOCK,   16'h0,    16'h0,  2'b00, 4'd2},  // R2 relock
      '{OP_WR, A_CTRL,   16'h0,    16'h0,  2'b00, 4'd3},  // R3 ignored
      '{OP_RD, A_CTRL,   16'h0,    16'hB,  2'b00, 4'd3},  // R3
      '{OP_RD, A_LOCK,   16'h0,    16'h0,  2'b00, 4'd2}   // R2
   };

   task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp,
                        input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d %s actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, input logic [15:0] exp, input int req);
      @(negedge clk);
      addr = a;
      #1;
      check(req, {16'h0, rdata}, {16'h0, exp}, "read");
   endtask

   task automatic tk(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic outs(input logic [1:0] exp, input int req);
      #1;
      check(req, {30'h0, rst_req_o, irq_o}, {30'h0, exp}, "outputs");
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         case (VT[i].op)
            OP_WR:   wr(VT[i].addr, VT[i].data);
            OP_RD:   rd(VT[i].addr, VT[i].exp, int'(VT[i].req));
            default: tk(int'(VT[i].data));
         endcase
         outs(VT[i].eo, int'(VT[i].req));
      end

      // R6 R7: reload while counting, borrow across the halves
      wr(A_LOCK, 16'hE551);
      wr(A_LD_HI, 16'h1);
      wr(A_LD_LO, 16'h0);
      tk(3);
      rd(A_CNT_HI, 16'h1, 6);
      rd(A_CNT_LO, 16'h0, 6);
      tk(1);
      rd(A_CNT_HI, 16'h0, 7);
      rd(A_CNT_LO, 16'hFFFF, 7);
      outs(2'b00, 7);

      // R5: a second load write restarts the wait
      wr(A_PR_LO, 16'h3);
      tk(2);
      wr(A_PR_LO, 16'h3);
      tk(2);
      rd(A_STAT, 16'h10, 5);
      tk(1);
      rd(A_STAT, 16'h0, 5);
      rd(A_CNT_HI, 16'h1, 6);  // R6 service reload

      // R9: clearing count enable drops the request, raw flag stays
      wr(A_LD_HI, 16'h0);
      wr(A_LD_LO, 16'h2);
      tk(3);
      rd(A_CNT_LO, 16'h2, 6);
      tk(2);
      outs(2'b10, 9);
      wr(A_CTRL, 16'h9);
      outs(2'b00, 9);
      rd(A_STAT, 16'h8, 9);

      // R1: reset in mid-run
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      rd(A_CTRL, 16'h0, 1);
      rd(A_LOCK, 16'h0, 1);
      rd(A_CNT_LO, 16'h0, 1);
      rd(A_STAT, 16'h0, 1);
      outs(2'b00, 1);

      finish_run();
   end
endmodule